// File: doc/BRIEF.md
# Operand Bypass and Load Interlock Unit

This block is the hazard logic of a five-stage in-order integer pipeline (fetch, decode with register read, execute, memory, write-back). Each cycle it looks at the source register numbers of the instruction now in execute. It compares them with the destination numbers of the two older instructions still in flight, the one in the memory stage and the one in write-back. From those comparisons it steers both ALU operand multiplexers so that a result not yet written to the register file is taken from the pipeline register that holds it.

It also watches the instruction in decode. When that instruction needs the result of a load that is currently in execute, it freezes the program counter and the fetch/decode register for one cycle and turns the execute-stage entry into a no-op. A store whose only dependence on the load is its data register is not frozen. The loaded value is instead handed to the store's data path one stage later, when the load sits in write-back and the store sits in memory. Register zero reads as constant zero and never takes part in any match.

The unit is purely combinational. An instruction that does not read a source must present register number 0 for that source.

Top module: `hazard_unit`

## Requirements
- R1: `fwd_a_sel` is 2'b10 (take the memory-stage result) when `mem_wen` is 1, `mem_rd` is nonzero and `mem_rd` equals `ex_rs1`.
- R2: Otherwise, `fwd_a_sel` is 2'b01 (take the write-back result) when `wb_wen` is 1, `wb_rd` is nonzero and `wb_rd` equals `ex_rs1`.
- R3: When neither producer matches, `fwd_a_sel` is 2'b00 (register file value), and the value 2'b11 never appears on either select.
- R4: `fwd_b_sel` follows the rules of R1 to R3 with `ex_rs2` in place of `ex_rs1`, independently of operand A.
- R5: When the memory-stage and write-back destinations both match a source, the select for that source is 2'b10.
- R6: A register number of 0 never produces a forward, a store-data forward or a stall, even when every other condition holds.
- R7: A producer whose write enable is 0 is never forwarded from, even when its destination matches.
- R8: `stall_front` is 1 exactly when `ex_is_load` and `ex_wen` are 1, `ex_rd` is nonzero, and `ex_rd` equals `id_rs1`, or equals `id_rs2` while `id_is_store` is 0.
- R9: A store in decode (`id_is_store` 1) whose `id_rs2` equals the load's `ex_rd`, and whose `id_rs1` does not, causes no stall. If its `id_rs1` equals the load's `ex_rd`, it does stall.
- R10: `st_data_sel` is 1 exactly when `mem_is_store` and `wb_wen` are 1, `wb_rd` is nonzero and `wb_rd` equals `mem_rs2`. Otherwise it is 0.
- R11: `bubble_idex` always equals `stall_front`, and both are 0 whenever `ex_is_load` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | REG_AW | First source register of the instruction in decode |
| id_rs2 | input | REG_AW | Second source register of the instruction in decode |
| id_is_store | input | 1 | Instruction in decode is a store (rs2 is its data) |
| ex_rs1 | input | REG_AW | First source register of the instruction in execute |
| ex_rs2 | input | REG_AW | Second source register of the instruction in execute |
| ex_rd | input | REG_AW | Destination of the instruction in execute |
| ex_wen | input | 1 | Instruction in execute writes a register |
| ex_is_load | input | 1 | Instruction in execute is a load |
| mem_rd | input | REG_AW | Destination held in the execute/memory register |
| mem_wen | input | 1 | Write enable held in the execute/memory register |
| mem_rs2 | input | REG_AW | Data source register of the instruction in memory |
| mem_is_store | input | 1 | Instruction in memory is a store |
| wb_rd | input | REG_AW | Destination held in the memory/write-back register |
| wb_wen | input | 1 | Write enable held in the memory/write-back register |
| fwd_a_sel | output | 2 | ALU operand A source: 00 file, 10 memory stage, 01 write-back |
| fwd_b_sel | output | 2 | ALU operand B source, same encoding |
| st_data_sel | output | 1 | Store data taken from the write-back result |
| stall_front | output | 1 | Hold the program counter and the fetch/decode register |
| bubble_idex | output | 1 | Load a no-op control word into the decode/execute register |

## Verification
The unit holds no state, so any fault in its comparison or priority logic shows on the select and stall pins in the same cycle as the input pattern that exposes it. A wrong priority shows only when both producers match. A missing zero-register guard shows only with register 0 on both sides. A wrong store exemption shows only with a load in execute and a store in decode. Directed scenarios therefore set up each of these patterns explicitly. Each one also includes a close variant that must give the opposite answer.

// File: rtl/hz_pkg.sv
// Shared definitions for the hazard unit.
// Assumes a register file of 2**REG_AW entries with entry 0 hard-wired to zero.
package hz_pkg;
    parameter int unsigned REG_AW = 5;

    // Operand source encoding; one hot or zero, never both bits set.
    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_WB  = 2'b01,
        SEL_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_operand_fwd.sv
// Chooses the source of one ALU operand in execute.
// Assumes a source number of 0 means "no source or zero register".
module hz_operand_fwd
    import hz_pkg::*;
#(
    parameter int unsigned AW = REG_AW
) (
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output fwd_sel_e      sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic hit_mem;
    logic hit_wb;

    // Compare against each producer; the newer one wins.
    always_comb begin
        hit_mem = mem_wen && (mem_rd != ZERO_REG) && (mem_rd == src);
        hit_wb  = wb_wen  && (wb_rd  != ZERO_REG) && (wb_rd  == src);
        if (hit_mem)     sel = SEL_MEM;
        else if (hit_wb) sel = SEL_WB;
        else             sel = SEL_RF;
    end

    // Checks on the chosen source.
    always_comb begin
        assert_sel_legal_R3: assert (sel != fwd_sel_e'(2'b11));
        if (src == ZERO_REG) begin
            assert_zero_src_R6: assert (sel == SEL_RF);
        end
        if (!mem_wen && !wb_wen) begin
            assert_no_wen_R7: assert (sel == SEL_RF);
        end
        if (sel == SEL_WB) begin
            assert_wb_needs_match_R2: assert (wb_rd == src);
        end
    end
endmodule

// File: rtl/hz_load_interlock.sv
// Detects a load in execute whose result the instruction in decode needs now.
// Assumes a store reads its data register in memory, so that match is exempt.
module hz_load_interlock
    import hz_pkg::*;
#(
    parameter int unsigned AW = REG_AW
) (
    input  logic [AW-1:0] id_rs1,
    input  logic [AW-1:0] id_rs2,
    input  logic          id_is_store,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          hold
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    logic load_live;
    logic need_a;
    logic need_b;

    // Raise hold when an early source reads the pending load result.
    always_comb begin
        load_live = ex_is_load && ex_wen && (ex_rd != ZERO_REG);
        need_a    = (id_rs1 == ex_rd);
        need_b    = (id_rs2 == ex_rd) && !id_is_store;
        hold      = load_live && (need_a || need_b);
    end

    // Checks on the interlock.
    always_comb begin
        if (!ex_is_load) begin
            assert_only_loads_R11: assert (!hold);
        end
        if (ex_rd == ZERO_REG) begin
            assert_zero_dest_R6: assert (!hold);
        end
        if (id_is_store && (id_rs1 != ex_rd)) begin
            assert_store_data_exempt_R9: assert (!hold);
        end
    end
endmodule

// File: rtl/hz_store_fwd.sv
// Routes the write-back result into the data of a store in the memory stage.
// Assumes mem_rs2 is the store data register.
module hz_store_fwd
    import hz_pkg::*;
#(
    parameter int unsigned AW = REG_AW
) (
    input  logic [AW-1:0] mem_rs2,
    input  logic          mem_is_store,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic          st_sel
);
    localparam logic [AW-1:0] ZERO_REG = '0;

    // Match store data source against the write-back destination.
    always_comb begin
        st_sel = mem_is_store && wb_wen && (wb_rd != ZERO_REG) && (wb_rd == mem_rs2);
    end

    // Checks on the store-data path.
    always_comb begin
        if (!mem_is_store) begin
            assert_store_only_R10: assert (!st_sel);
        end
        if (mem_rs2 == ZERO_REG) begin
            assert_store_zero_R6: assert (!st_sel);
        end
    end
endmodule

// File: rtl/hazard_unit.sv
// Hazard unit top: ALU operand bypass, store-data bypass and load interlock.
// Assumes only read-after-write hazards occur (reads in stage 2, writes in 5).
module hazard_unit
    import hz_pkg::*;
#(
    parameter int unsigned REG_AW_P = REG_AW
) (
    input  logic [REG_AW_P-1:0] id_rs1,
    input  logic [REG_AW_P-1:0] id_rs2,
    input  logic                id_is_store,
    input  logic [REG_AW_P-1:0] ex_rs1,
    input  logic [REG_AW_P-1:0] ex_rs2,
    input  logic [REG_AW_P-1:0] ex_rd,
    input  logic                ex_wen,
    input  logic                ex_is_load,
    input  logic [REG_AW_P-1:0] mem_rd,
    input  logic                mem_wen,
    input  logic [REG_AW_P-1:0] mem_rs2,
    input  logic                mem_is_store,
    input  logic [REG_AW_P-1:0] wb_rd,
    input  logic                wb_wen,
    output logic [1:0]          fwd_a_sel,
    output logic [1:0]          fwd_b_sel,
    output logic                st_data_sel,
    output logic                stall_front,
    output logic                bubble_idex
);
    localparam int unsigned N_OPS = 2;

    logic [REG_AW_P-1:0] op_src [N_OPS];
    fwd_sel_e            op_sel [N_OPS];
    logic                hold;

    // Gather the execute-stage sources into one array.
    always_comb begin
        op_src[0] = ex_rs1;
        op_src[1] = ex_rs2;
    end

    for (genvar i = 0; i < N_OPS; i++) begin : g_op
        hz_operand_fwd #(.AW(REG_AW_P)) u_fwd (
            .src     (op_src[i]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (op_sel[i])
        );
    end

    hz_store_fwd #(.AW(REG_AW_P)) u_st (
        .mem_rs2      (mem_rs2),
        .mem_is_store (mem_is_store),
        .wb_rd        (wb_rd),
        .wb_wen       (wb_wen),
        .st_sel       (st_data_sel)
    );

    hz_load_interlock #(.AW(REG_AW_P)) u_lock (
        .id_rs1      (id_rs1),
        .id_rs2      (id_rs2),
        .id_is_store (id_is_store),
        .ex_rd       (ex_rd),
        .ex_wen      (ex_wen),
        .ex_is_load  (ex_is_load),
        .hold        (hold)
    );

    // Drive the pipeline control outputs.
    always_comb begin
        fwd_a_sel   = op_sel[0];
        fwd_b_sel   = op_sel[1];
        stall_front = hold;
        bubble_idex = hold;
    end

    // Cross-checks between the two operand paths.
    always_comb begin
        if (ex_rs1 == ex_rs2) begin
            assert_same_src_same_sel_R4: assert (fwd_a_sel == fwd_b_sel);
        end
        if (mem_wen && mem_rd == ex_rs1 && ex_rs1 != '0) begin
            assert_mem_priority_R5: assert (fwd_a_sel == 2'b10);
        end
    end
endmodule

// File: tb/hazard_unit_tb.sv
module hazard_unit_tb;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd;
    logic       id_is_store, ex_wen, ex_is_load, mem_wen, mem_is_store, wb_wen;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic       st_data_sel, stall_front, bubble_idex;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    hazard_unit u_dut (
        .id_rs1(id_rs1), .id_rs2(id_rs2), .id_is_store(id_is_store),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen),
        .ex_is_load(ex_is_load), .mem_rd(mem_rd), .mem_wen(mem_wen),
        .mem_rs2(mem_rs2), .mem_is_store(mem_is_store), .wb_rd(wb_rd),
        .wb_wen(wb_wen), .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .st_data_sel(st_data_sel), .stall_front(stall_front),
        .bubble_idex(bubble_idex)
    );

    task automatic chk(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        @(negedge clk);
        {id_rs1, id_rs2, ex_rs1, ex_rs2, ex_rd, mem_rd, mem_rs2, wb_rd} = '0;
        {id_is_store, ex_wen, ex_is_load, mem_wen, mem_is_store, wb_wen} = '0;
    endtask

    task automatic settle();
        #2;
    endtask

    task automatic t_idle();
        idle_inputs(); settle();
        chk("R3 idle a", fwd_a_sel, 0);
        chk("R3 idle b", fwd_b_sel, 0);
        chk("R10 idle st", st_data_sel, 0);
        chk("R11 idle stall", stall_front, 0);
        chk("R11 idle bubble", bubble_idex, 0);
    endtask

    task automatic t_back_to_back();
        idle_inputs();
        ex_rs1 = 5'd1; ex_rs2 = 5'd3; mem_rd = 5'd1; mem_wen = 1'b1;
        settle();
        chk("R1 adjacent a", fwd_a_sel, 2);
        chk("R4 b untouched", fwd_b_sel, 0);
        ex_rs1 = 5'd4; ex_rs2 = 5'd1;
        settle();
        chk("R4 adjacent b", fwd_b_sel, 2);
        chk("R3 a no match", fwd_a_sel, 0);
    endtask

    task automatic t_two_apart();
        idle_inputs();
        ex_rs1 = 5'd7; ex_rs2 = 5'd7; wb_rd = 5'd7; wb_wen = 1'b1;
        mem_rd = 5'd9; mem_wen = 1'b1;
        settle();
        chk("R2 two apart a", fwd_a_sel, 1);
        chk("R4 two apart b", fwd_b_sel, 1);
    endtask

    task automatic t_both_match();
        idle_inputs();
        ex_rs1 = 5'd12; ex_rs2 = 5'd5; mem_rd = 5'd12; mem_wen = 1'b1;
        wb_rd = 5'd12; wb_wen = 1'b1;
        settle();
        chk("R5 newer wins", fwd_a_sel, 2);
        chk("R3 other operand", fwd_b_sel, 0);
    endtask

    task automatic t_wen_off();
        idle_inputs();
        ex_rs1 = 5'd6; ex_rs2 = 5'd6; mem_rd = 5'd6; wb_rd = 5'd6;
        settle();
        chk("R7 no wen a", fwd_a_sel, 0);
        chk("R7 no wen b", fwd_b_sel, 0);
        wb_wen = 1'b1;
        settle();
        chk("R7 wb wen only", fwd_a_sel, 1);
    endtask

    task automatic t_reg_zero();
        idle_inputs();
        mem_rd = 5'd0; mem_wen = 1'b1; wb_rd = 5'd0; wb_wen = 1'b1;
        mem_rs2 = 5'd0; mem_is_store = 1'b1;
        ex_rd = 5'd0; ex_wen = 1'b1; ex_is_load = 1'b1;
        settle();
        chk("R6 zero a", fwd_a_sel, 0);
        chk("R6 zero b", fwd_b_sel, 0);
        chk("R6 zero store", st_data_sel, 0);
        chk("R6 zero stall", stall_front, 0);
    endtask

    task automatic t_load_use();
        idle_inputs();
        ex_rd = 5'd8; ex_wen = 1'b1; ex_is_load = 1'b1;
        id_rs1 = 5'd8; id_rs2 = 5'd2;
        settle();
        chk("R8 use rs1 stall", stall_front, 1);
        chk("R11 use rs1 bubble", bubble_idex, 1);
        id_rs1 = 5'd2; id_rs2 = 5'd8;
        settle();
        chk("R8 use rs2 stall", stall_front, 1);
        id_rs2 = 5'd9;
        settle();
        chk("R8 independent", stall_front, 0);
        id_rs2 = 5'd8; ex_is_load = 1'b0;
        settle();
        chk("R11 alu no stall", stall_front, 0);
        chk("R11 alu no bubble", bubble_idex, 0);
        ex_is_load = 1'b1; ex_wen = 1'b0;
        settle();
        chk("R8 load no wen", stall_front, 0);
    endtask

    task automatic t_load_store();
        idle_inputs();
        ex_rd = 5'd10; ex_wen = 1'b1; ex_is_load = 1'b1;
        id_is_store = 1'b1; id_rs1 = 5'd3; id_rs2 = 5'd10;
        settle();
        chk("R9 store data no stall", stall_front, 0);
        chk("R9 store data no bubble", bubble_idex, 0);
        id_rs1 = 5'd10;
        settle();
        chk("R9 store base stall", stall_front, 1);
        idle_inputs();
        mem_is_store = 1'b1; mem_rs2 = 5'd10; wb_rd = 5'd10; wb_wen = 1'b1;
        settle();
        chk("R10 load to store", st_data_sel, 1);
        mem_is_store = 1'b0;
        settle();
        chk("R10 not a store", st_data_sel, 0);
        mem_is_store = 1'b1; wb_wen = 1'b0;
        settle();
        chk("R10 wb no wen", st_data_sel, 0);
        wb_wen = 1'b1; wb_rd = 5'd11;
        settle();
        chk("R10 other reg", st_data_sel, 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_idle();
        t_back_to_back();
        t_two_apart();
        t_both_match();
        t_wen_off();
        t_reg_zero();
        t_load_use();
        t_load_store();
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule